// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block gathers ten interrupt sources into one request for the CPU. Each source has a pending flag, an enable bit and a programmable three-bit level from 0 to 7. A one-cycle pulse on a source's event input sets its pending flag, whether or not that source is enabled. Among the sources that are both pending and enabled, the one with the highest level wins. The block presents the winner's index and level on its outputs.

The request is raised only while the CPU's global interrupt-enable input is 1 and the CPU's current interrupt level is strictly below the winner's level. A source at level 0 therefore never interrupts. Software reaches the state through a small register port. Pending flags are cleared by writing 1 to them. When the CPU takes the request, it pulses the acknowledge input, and that clears the winner's flag. All outputs are combinational from registered state. Fetching the vector, saving CPU state and any DMA triggering belong to other blocks.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset all pending flags, enable bits and levels are 0, and `irq_req` is 0.
- R2: An event pulse on `src_evt[i]` sets pending flag i on the next clock edge, whatever the enable bit i holds.
- R3: A write to address 0 clears every pending flag whose `reg_wdata` bit is 1 and leaves the other flags unchanged. An event arriving in the same cycle as a clear of the same flag leaves that flag set.
- R4: Only sources with both the pending flag and the enable bit at 1 take part in arbitration. When no source qualifies, `irq_req`, `irq_id` and `irq_lvl` are all 0.
- R5: `irq_id` and `irq_lvl` give the qualifying source with the highest level.
- R6: Among qualifying sources of equal level, the lowest index wins.
- R7: `irq_req` is 0 whenever `cpu_ie` is 0.
- R8: `irq_req` is 1 only when `cpu_il` is strictly less than `irq_lvl`. A winner at level 0 therefore never raises a request.
- R9: `irq_ack` in a cycle with `irq_req` at 1 clears the winner's pending flag on the next edge and no other flag. `irq_ack` while `irq_req` is 0 changes nothing.
- R10: The register map is as follows. Address 0 reads the pending flags, with bit i for source i. Address 1 reads and writes the enable bits, with bit i for source i. Address 2+i reads and writes the level of source i in bits [2:0], and its upper bits read 0. Addresses 12 to 15 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 10 | Per-source event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data (combinational) |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_il | input | 3 | CPU current interrupt level |
| irq_ack | input | 1 | CPU acceptance strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_id | output | 4 | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |

## Verification
The bench sweeps every source at every level against every CPU level with the global enable both off and on. This catches an off-by-one in the level comparison, which would let a request through when the CPU level equals the winner's level, or would block a level-7 source. It drives many mixed flag, enable and level patterns with deliberate ties. An arbiter that takes the highest index on a tie, or that ignores the enable bit, then reports the wrong source.

Acknowledge sequences drain the flags one at a time. A design that clears the wrong flag, or that clears on an acknowledge given while no request is raised, leaves a flag pattern that differs from the expected one. A clear and an event on the same flag in the same cycle, and writes to unmapped addresses, are also checked at the register port.

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl #(
  parameter int NSRC = 10,
  parameter int LVLW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            src_evt,
  input  logic                       reg_we,
  input  logic [$clog2(NSRC+2)-1:0]  reg_addr,
  input  logic [NSRC-1:0]            reg_wdata,
  output logic [NSRC-1:0]            reg_rdata,
  input  logic                       cpu_ie,
  input  logic [LVLW-1:0]            cpu_il,
  input  logic                       irq_ack,
  output logic                       irq_req,
  output logic [$clog2(NSRC)-1:0]    irq_id,
  output logic [LVLW-1:0]            irq_lvl
);
  localparam int AW  = $clog2(NSRC+2);
  localparam int IDW = $clog2(NSRC);
  localparam logic [AW-1:0] A_FLAG = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);

  logic [NSRC-1:0] flag_q, en_q, pend, w1c, ack_clr;
  logic [LVLW-1:0] prio_q [NSRC];
  logic            any_pend;

  assign pend    = flag_q & en_q;
  assign w1c     = (reg_we && reg_addr == A_FLAG) ? reg_wdata : '0;
  assign ack_clr = (irq_ack && irq_req) ? ({{(NSRC-1){1'b0}}, 1'b1} << irq_id) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~(w1c | ack_clr)) | src_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            en_q <= '0;
    else if (reg_we && reg_addr == A_EN)   en_q <= reg_wdata;

  for (genvar g = 0; g < NSRC; g++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                 prio_q[g] <= '0;
      else if (reg_we && reg_addr == AW'(g + 2))  prio_q[g] <= reg_wdata[LVLW-1:0];
  end

  always_comb begin
    any_pend = 1'b0;
    irq_id   = '0;
    irq_lvl  = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && (!any_pend || prio_q[i] > irq_lvl)) begin
        any_pend = 1'b1;
        irq_id   = IDW'(i);
        irq_lvl  = prio_q[i];
      end
  end

  assign irq_req = any_pend && cpu_ie && (cpu_il < irq_lvl);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_FLAG)    reg_rdata = flag_q;
    else if (reg_addr == A_EN) reg_rdata = en_q;
    else
      for (int i = 0; i < NSRC; i++)
        if (reg_addr == AW'(i + 2)) reg_rdata[LVLW-1:0] = prio_q[i];
  end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_chk #(
  parameter int NSRC = 10,
  parameter int LVLW = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC-1:0]         src_evt,
  input logic                    cpu_ie,
  input logic [LVLW-1:0]         cpu_il,
  input logic                    irq_ack,
  input logic                    irq_req,
  input logic [$clog2(NSRC)-1:0] irq_id,
  input logic [LVLW-1:0]         irq_lvl,
  input logic [NSRC-1:0]         flag_q,
  input logic [NSRC-1:0]         en_q
);
  p_req_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cpu_ie);

  p_req_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cpu_il < irq_lvl) && (irq_lvl != '0));

  p_req_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag_q[irq_id] && en_q[irq_id]);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !src_evt[irq_id]) |=> !flag_q[$past(irq_id)]);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      src_evt[g] |=> flag_q[g]);
    p_rise_needs_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[g]) |-> $past(src_evt[g]));
  end
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NSRC(NSRC), .LVLW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
  .irq_ack(irq_ack), .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl),
  .flag_q(flag_q), .en_q(en_q));

// File: tb/lvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb;
  localparam int N = 10;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_evt = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 0, cpu_ie = 0, irq_ack = 0, irq_req;
  logic [3:0] reg_addr = '0, irq_id;
  logic [2:0] cpu_il = '0, irq_lvl;

  lvl_irq_ctrl u_dut (.*);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [N-1:0] m_flag = '0, m_en = '0;
  int m_prio [N];

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(int a, int d);
    reg_we = 1; reg_addr = 4'(a); reg_wdata = N'(d);
    step();
    reg_we = 0;
    if (a == 0) m_flag &= ~N'(d);
    else if (a == 1) m_en = N'(d);
    else if (a < N + 2) m_prio[a-2] = d % 8;
  endtask

  task automatic evt(int m);
    src_evt = N'(m);
    step();
    src_evt = '0;
    m_flag |= N'(m);
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 4'(a); #1; d = int'(reg_rdata);
  endtask

  task automatic model(output int id, output int lvl, output bit req);
    bit any = 0; id = 0; lvl = 0;
    for (int i = 0; i < N; i++)
      if (m_flag[i] && m_en[i] && (!any || m_prio[i] > lvl)) begin any = 1; id = i; lvl = m_prio[i]; end
    req = any && cpu_ie && (int'(cpu_il) < lvl);
  endtask

  task automatic chk_out(string r);
    int id, lvl; bit req;
    #1; model(id, lvl, req);
    chk({r, " req"}, int'(irq_req), int'(req));
    chk({r, " id"}, int'(irq_id), id);
    chk({r, " lvl"}, int'(irq_lvl), lvl);
  endtask

  task automatic ack();
    int id, lvl; bit req;
    model(id, lvl, req);
    irq_ack = 1; step(); irq_ack = 0;
    if (req) m_flag[id] = 1'b0;
  endtask

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int d;
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    #35 rst_n = 1;
    step();
    // R1 reset state
    chk("R1 req", int'(irq_req), 0);
    rd(0, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 en", d, 0);
    for (int i = 0; i < N; i++) begin rd(i + 2, d); chk("R1 prio", d, 0); end

    // R2 flags set while disabled; R4 nothing qualifies
    cpu_ie = 1;
    for (int i = 0; i < N; i++) begin
      wr(3, 7); evt(1 << i);
      rd(0, d); chk("R2 flag", d, int'(m_flag));
      chk_out("R4 disabled");
    end
    // R3 write-1-to-clear, partial
    wr(0, 'h155); rd(0, d); chk("R3 partial", d, 'h2AA);
    wr(0, 'h3FF); rd(0, d); chk("R3 all", d, 0);
    // R3 event and clear together
    evt('h3FF);
    reg_we = 1; reg_addr = 0; reg_wdata = 'h0FF; src_evt = 'h003;
    step();
    reg_we = 0; src_evt = '0; m_flag = (m_flag & ~N'('h0FF)) | N'('h003);
    rd(0, d); chk("R3 evt wins", d, 'h303);
    wr(0, 'h3FF);

    // R10 readback and unmapped addresses
    wr(1, 'h2B5);
    for (int i = 0; i < N; i++) wr(i + 2, (i * 5 + 3) | 'h3F8);
    rd(1, d); chk("R10 en", d, 'h2B5);
    for (int i = 0; i < N; i++) begin rd(i + 2, d); chk("R10 prio", d, (i * 5 + 3) % 8); end
    for (int a = N + 2; a < 16; a++) begin
      wr(a, 'h3FF); rd(a, d); chk("R10 unmapped read", d, 0);
    end
    rd(1, d); chk("R10 en kept", d, 'h2B5);
    for (int i = 0; i < N; i++) begin rd(i + 2, d); chk("R10 prio kept", d, (i * 5 + 3) % 8); end

    // R5 R7 R8 single-source sweep
    for (int i = 0; i < N; i++)
      for (int l = 0; l < 8; l++) begin
        wr(0, 'h3FF); wr(1, 1 << i); wr(i + 2, l); evt(1 << i);
        for (int ie = 0; ie < 2; ie++)
          for (int il = 0; il < 8; il++) begin
            cpu_ie = 1'(ie); cpu_il = 3'(il);
            chk_out(ie == 0 ? "R7 gate" : "R8 level");
          end
      end

    // R4 R5 R6 mixed patterns with ties
    for (int p = 0; p < 48; p++) begin
      wr(0, 'h3FF);
      wr(1, (p * 173 + 91) % 1024);
      for (int i = 0; i < N; i++) wr(i + 2, (p % 4 == 0) ? 5 : ((i * p + p / 3) % 8));
      evt((p * 389 + 5) % 1024);
      cpu_ie = 1;
      for (int il = 0; il < 8; il += 3) begin cpu_il = 3'(il); chk_out("R6 mix"); end
    end

    // R9 acknowledge drains flags
    wr(1, 'h3FF);
    for (int i = 0; i < N; i++) wr(i + 2, (i * 3) % 8);
    evt('h3FF);
    cpu_ie = 0; cpu_il = 0;
    ack(); rd(0, d); chk("R9 ack no req", d, int'(m_flag));
    cpu_ie = 1;
    for (int k = 0; k < 12; k++) begin
      chk_out("R9 before ack");
      ack(); rd(0, d); chk("R9 flags", d, int'(m_flag));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule